// File: doc/BRIEF.md
# Lockable Cache Way Replacement Selector

This block names the victim way for the next line fill of a four-way set-associative cache after a read miss. It holds a small segment counter, which steps in a fixed order, and a free-running shift-register generator. A mode input chooses which of the two supplies the victim. The cache controller reads `victimWay` when it allocates a line and pulses `allocate` in that cycle, which moves the sequential counter on.

A two-bit lock base narrows the choice. Ways numbered below the base are locked: they hold critical code or data and are never offered as victims. Lowering the base returns those ways to the pool at once. Tag storage, hit detection and the fill data path are outside this block.

Top module: `way_victim_select`

## Requirements
- R1: `victimWay` is never below `lockBase`; it always lies in the range `lockBase` to 3.
- R2: In sequential mode (`randomMode`=0), with `lockBase` unchanged, an `allocate` pulse in a cycle where the victim is below 3 makes the victim of the next cycle one higher.
- R3: In sequential mode an `allocate` pulse in a cycle where the victim is 3 makes the next victim equal to the lock base present in that cycle.
- R4: In sequential mode, with no `allocate` and `lockBase` unchanged, the victim holds its value.
- R5: In pseudo-random mode (`randomMode`=1) the victim is `lockBase + (S mod (4 - lockBase))`, where S is a 4-bit generator state. S shifts left by one bit on every clock, whatever the mode, and the new bit 0 is bit 3 XOR bit 2 of the old state.
- R6: A synchronous reset (`rstN`=0 at a clock edge) loads the counter with the current `lockBase` and loads S with 4'b0001. In sequential mode the first victim after reset therefore equals the lock base.
- R7: When `lockBase` is 3, the victim is 3 in both modes.
- R8: If `lockBase` moves above the counter, the victim equals the new base in the same cycle and the counter continues from there. An `allocate` in that cycle steps from the new base. Lowering `lockBase` makes the freed ways reachable again: the next wrap goes to the lower base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| randomMode | input | 1 | 1 selects pseudo-random victims, 0 selects sequential victims |
| lockBase | input | 2 | Lowest way that may be replaced |
| allocate | input | 1 | A line fill takes the current victim in this cycle |
| victimWay | output | 2 | Way to be replaced by the next fill |

## Verification
Two functions can fall in the same cycle: a lock base change and an allocation step. The bench raises and lowers `lockBase` in the very cycles that carry `allocate`, both while the counter sits below the new base and while it sits at 3. The expected victim then follows R8 and R3 together: the counter first snaps to the new base, then steps or wraps from there. A behavioural model receives the same inputs, and the bench compares its victim with the design's on every clock. The bench also switches the mode in the middle of such cycles, so that counter snapping under pseudo-random mode can be observed once sequential mode returns.

// File: rtl/way_sel_pkg.sv
package way_sel_pkg;

  // Strobes from control to the datapath
  typedef struct packed {
    logic loadBase;   // reset: counter takes the lock base
    logic snapBase;   // counter below base: pull it up
    logic stepCnt;    // allocation in sequential mode: advance
    logic wrapCnt;    // advance from the top way: return to base
    logic seedGen;    // reset: load generator seed
    logic shiftGen;   // advance generator
  } selStrobes_t;

endpackage

// File: rtl/way_sel_ctrl.sv
module way_sel_ctrl
  import way_sel_pkg::*;
(
  input  logic        rstN,
  input  logic        randomMode,
  input  logic        allocate,
  input  logic        belowBase,
  input  logic        effAtTop,
  output selStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.seedGen  = !rstN;
    strobes.shiftGen = rstN;
    if (!rstN) begin
      strobes.loadBase = 1'b1;
    end else if (allocate && !randomMode) begin
      strobes.stepCnt = 1'b1;
      strobes.wrapCnt = effAtTop;
    end else begin
      strobes.snapBase = belowBase;
    end
  end

endmodule

// File: rtl/way_sel_datapath.sv
module way_sel_datapath
  import way_sel_pkg::*;
#(
  parameter int WAY_BITS  = 2,
  parameter int GEN_BITS  = 4,
  parameter logic [GEN_BITS-1:0] GEN_SEED = 4'b0001,
  parameter logic [GEN_BITS-1:0] GEN_TAPS = 4'b1100
) (
  input  logic                clk,
  input  logic                randomMode,
  input  logic [WAY_BITS-1:0] lockBase,
  input  selStrobes_t         strobes,
  output logic                belowBase,
  output logic                effAtTop,
  output logic [WAY_BITS-1:0] victimWay
);

  localparam int NUM_WAYS = 1 << WAY_BITS;
  localparam int CALC_W   = GEN_BITS + WAY_BITS + 1;
  localparam logic [WAY_BITS-1:0] TOP_WAY = WAY_BITS'(NUM_WAYS - 1);

  logic [WAY_BITS-1:0] seqCnt;
  logic [WAY_BITS-1:0] effCnt;
  logic [GEN_BITS-1:0] genState;
  logic                genFeedback;
  logic [CALC_W-1:0]   span;
  logic [CALC_W-1:0]   randOffset;
  logic [WAY_BITS-1:0] randWay;

  // Counter as seen after lock-base clamping
  assign belowBase = seqCnt < lockBase;
  assign effCnt    = belowBase ? lockBase : seqCnt;
  assign effAtTop  = effCnt == TOP_WAY;

  always_ff @(posedge clk) begin
    if (strobes.loadBase)      seqCnt <= lockBase;
    else if (strobes.wrapCnt)  seqCnt <= lockBase;
    else if (strobes.stepCnt)  seqCnt <= effCnt + WAY_BITS'(1);
    else if (strobes.snapBase) seqCnt <= lockBase;
  end

  // Shift-register generator, taps chosen by parameter
  assign genFeedback = ^(genState & GEN_TAPS);

  always_ff @(posedge clk) begin
    if (strobes.seedGen)       genState <= GEN_SEED;
    else if (strobes.shiftGen) genState <= {genState[GEN_BITS-2:0], genFeedback};
  end

  // Map generator state into the unlocked range
  assign span       = CALC_W'(NUM_WAYS) - CALC_W'(lockBase);
  assign randOffset = CALC_W'(genState) % span;
  assign randWay    = lockBase + WAY_BITS'(randOffset);

  assign victimWay = randomMode ? randWay : effCnt;

endmodule

// File: rtl/way_victim_select.sv
module way_victim_select
  import way_sel_pkg::*;
#(
  parameter int WAY_BITS = 2,
  parameter int GEN_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                randomMode,
  input  logic [WAY_BITS-1:0] lockBase,
  input  logic                allocate,
  output logic [WAY_BITS-1:0] victimWay
);

  selStrobes_t strobes;
  logic        belowBase;
  logic        effAtTop;

  way_sel_ctrl u_ctrl (
    .rstN       (rstN),
    .randomMode (randomMode),
    .allocate   (allocate),
    .belowBase  (belowBase),
    .effAtTop   (effAtTop),
    .strobes    (strobes)
  );

  way_sel_datapath #(
    .WAY_BITS (WAY_BITS),
    .GEN_BITS (GEN_BITS)
  ) u_dp (
    .clk        (clk),
    .randomMode (randomMode),
    .lockBase   (lockBase),
    .strobes    (strobes),
    .belowBase  (belowBase),
    .effAtTop   (effAtTop),
    .victimWay  (victimWay)
  );

endmodule

// File: rtl/way_sel_checker.sv
module way_sel_checker #(
  parameter int WAY_BITS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                randomMode,
  input logic [WAY_BITS-1:0] lockBase,
  input logic                allocate,
  input logic [WAY_BITS-1:0] victimWay
);

  localparam logic [WAY_BITS-1:0] TOP_WAY = '1;

  logic pastRun;
  always_ff @(posedge clk) pastRun <= rstN;

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rstN)
    pastRun |-> victimWay >= lockBase);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && !randomMode && $past(!randomMode && allocate && rstN)
     && $stable(lockBase) && $past(victimWay) != TOP_WAY)
    |-> victimWay == $past(victimWay) + WAY_BITS'(1));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && !randomMode && $past(!randomMode && allocate && rstN)
     && $past(victimWay) == TOP_WAY && lockBase == $past(lockBase))
    |-> victimWay == lockBase);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && !randomMode && $past(!randomMode && !allocate && rstN)
     && $stable(lockBase))
    |-> $stable(victimWay));

  a_r7_top_locked: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && lockBase == TOP_WAY) |-> victimWay == TOP_WAY);

endmodule

bind way_victim_select way_sel_checker #(.WAY_BITS(WAY_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .randomMode (randomMode),
  .lockBase   (lockBase),
  .allocate   (allocate),
  .victimWay  (victimWay)
);

// File: tb/way_victim_select_bench.sv
module way_victim_select_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       randomMode = 1'b0;
  logic [1:0] lockBase = 2'd1;
  logic       allocate = 1'b0;
  logic [1:0] victimWay;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int mCnt   = 0;   // model counter
  int mGen   = 1;   // model generator state
  string curTag = "R6";

  always #5 clk = ~clk;

  way_victim_select u_way_victim_select (
    .clk        (clk),
    .rstN       (rstN),
    .randomMode (randomMode),
    .lockBase   (lockBase),
    .allocate   (allocate),
    .victimWay  (victimWay)
  );

  function automatic int expVictim();
    int l = int'(lockBase);
    if (randomMode) return l + (mGen % (4 - l));
    return (mCnt < l) ? l : mCnt;
  endfunction

  // Behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int l, eff, fb;
    l = int'(lockBase);
    cycles++;
    if (!rstN) begin
      mCnt = l;
      mGen = 1;
    end else begin
      fb   = ((mGen >> 3) ^ (mGen >> 2)) & 1;
      mGen = ((mGen << 1) & 15) | fb;
      eff  = (mCnt < l) ? l : mCnt;
      if (allocate && !randomMode) mCnt = (eff == 3) ? l : eff + 1;
      else mCnt = eff;
    end
  end

  task automatic compareNow();
    int e = expVictim();
    checks++;
    if (int'(victimWay) != e) begin
      fails++;
      $display("FAIL %s: victimWay=%0d expected=%0d (lockBase=%0d mode=%0d)",
               curTag, victimWay, e, lockBase, randomMode);
    end
    checks++;
    if (victimWay < lockBase) begin
      fails++;
      $display("FAIL R1: victimWay=%0d expected >= %0d", victimWay, lockBase);
    end
  endtask

  // One cycle: check at the falling edge, then apply new inputs
  task automatic cyc(input logic rm, input logic [1:0] lb, input logic al);
    @(negedge clk);
    if (rstN) compareNow();
    randomMode = rm;
    lockBase   = lb;
    allocate   = al;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R6: first victim after reset equals lock base
    curTag = "R6";
    cyc(0, 2'd1, 1'b0);
    // R2, R3: sequential walk with wraps at base 0
    curTag = "R2/R3";
    for (int i = 0; i < 10; i++) cyc(0, 2'd0, 1'b1);
    // R4: hold without allocation
    curTag = "R4";
    for (int i = 0; i < 4; i++) cyc(0, 2'd0, 1'b0);
    // R8: raise base, with and without a same-cycle allocation
    curTag = "R8";
    cyc(0, 2'd0, 1'b0);
    cyc(0, 2'd2, 1'b1);
    cyc(0, 2'd2, 1'b1);
    cyc(0, 2'd2, 1'b1);
    cyc(0, 2'd0, 1'b1);
    cyc(0, 2'd0, 1'b1);
    cyc(0, 2'd0, 1'b0);
    cyc(0, 2'd3, 1'b1);
    cyc(0, 2'd1, 1'b1);
    cyc(0, 2'd1, 1'b1);
    cyc(0, 2'd1, 1'b1);
    // R7: top way locked in both modes
    curTag = "R7";
    for (int i = 0; i < 6; i++) cyc(i[0], 2'd3, 1'b1);
    // R5: pseudo-random mode for each lock base
    curTag = "R5";
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 18; i++) cyc(1, 2'(b), i[1]);
    // R8 with mode switches: counter snapping under random mode
    curTag = "R8";
    cyc(0, 2'd0, 1'b0);
    cyc(1, 2'd0, 1'b0);
    cyc(1, 2'd2, 1'b1);
    cyc(0, 2'd2, 1'b0);
    // Mixed traffic
    curTag = "R1-mix";
    for (int i = 0; i < 300; i++) begin
      int h = (i * 37 + 11) ^ (i >> 2);
      cyc(h[4] & h[1], 2'(h >> 5), h[0] | h[3]);
    end
    // R6: reset mid-run with base 2
    rstN = 1'b0;
    lockBase = 2'd2;
    randomMode = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    curTag = "R6";
    cyc(0, 2'd2, 1'b0);
    curTag = "R5";
    for (int i = 0; i < 8; i++) cyc(1, 2'd0, 1'b0);
    cyc(1, 2'd0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule